// File: doc/BRIEF.md
# Entropy Bitstream Health Monitor

This block continuously screens the raw serial output of one or more noise sources for two signs of a degraded entropy source. The first is a constant run: the same bit value repeating for too long. The second is a locked oscillation: the same alternating two-bit pair ("01" or "10") repeating for too long. Each source presents one sampled bit per valid strobe. Each source has its own pair of independent counters, and a failure on any lane feeds a shared status.

The block produces three kinds of indication. A live error level is high for as long as some source is in a failing condition. A sticky per-source error flag records that a failure has happened. An interrupt-pending flag is separate from the status flags. Software clears the sticky flags and the pending flag with dedicated clear strobes. Dropping `enable` restarts every counter and the pair alignment.

Top module: `entropy_health_mon`

## Requirements
- R1: A source whose counters start from cleared, and which then delivers more than RUN_LIMIT (default 64) consecutive valid 0 bits, drives `err_live` high once the (RUN_LIMIT+1)th bit has been taken. A run of exactly RUN_LIMIT zeros leaves `err_live` low.
- R2: The same constant-run rule applies to runs of 1 bits.
- R3: Pairs are formed from consecutive valid bits, without overlap, and aligned to the first valid bit after `enable` rises. The first bit of a pair is the left character: "01" means 0 then 1. More than PAIR_LIMIT (default 32) consecutive identical pairs of "01", or of "10", drive `err_live` high once the (PAIR_LIMIT+1)th pair completes. Exactly PAIR_LIMIT such pairs do not.
- R4: The pair count restarts at 1 when an alternating pair differs from the previous pair. It drops to 0 on any "00" or "11" pair.
- R5: Each source is tested independently. Bit i of `src_err` reflects only source i. `err_status` is the OR of `src_err`.
- R6: A bit is taken only in a cycle where its `smp_vld` bit is high. `smp_bit` is ignored in every other cycle.
- R7: A source's `src_err` bit sets on the clock edge after that source's failure is live. It then stays set until a `stat_clr` strobe arrives. If the failure is still live at the clearing edge, the set wins.
- R8: `err_live` returns low on the edge that takes a bit that breaks the constant run, or the bit that completes a pair breaking the pair run. The sticky flags remain set.
- R9: `irq` sets on the edge after a live failure, but only if `irq_en` is high. It stays set until an `irq_clr` strobe arrives, and `stat_clr` has no effect on it.
- R10: While `enable` is low, all run and pair counters and the pair alignment are held at reset, and bits on the inputs are ignored.
- R11: Counters saturate at their failing value. An arbitrarily long constant run keeps `err_live` high and does not wrap back to a passing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; when low, counters are held cleared |
| irq_en | input | 1 | Allows a live failure to set the interrupt-pending flag |
| smp_bit | input | N_SRC | Sampled raw bit, one per source |
| smp_vld | input | N_SRC | Valid strobe for each source's bit |
| stat_clr | input | 1 | Clears the sticky per-source error flags |
| irq_clr | input | 1 | Clears the interrupt-pending flag |
| src_err | output | N_SRC | Sticky per-source error flags |
| err_live | output | 1 | High while any source is currently failing |
| err_status | output | 1 | OR of the sticky per-source flags |
| irq | output | 1 | Interrupt-pending flag |

## Verification
The hardest situation to reach is the exact threshold of the pair test. It needs an unbroken train of identical pairs in the correct alignment, and no constant run or stray valid bit may disturb the count. The bench restarts the lanes through `enable` before every trial, which pins the alignment. It then sweeps pair counts and run lengths across each threshold for both patterns and both bit values. Separate sequences insert a "00" pair or a swapped pair just under the limit, and these show whether the count restarts or carries on.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

   typedef enum logic [1:0] {
      PR_00 = 2'b00,
      PR_01 = 2'b01,
      PR_10 = 2'b10,
      PR_11 = 2'b11
   } pair_t;

   function automatic logic pair_alternates(pair_t p);
      return (p == PR_01) || (p == PR_10);
   endfunction

endpackage

// File: rtl/ehm_run_counter.sv
module ehm_run_counter #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic vld,
   input  logic bit_in,
   output logic fail
);
   localparam int SAT = LIMIT + 1;
   localparam int W   = $clog2(SAT + 1);

   logic [W-1:0] cnt;
   logic         last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         last <= 1'b0;
      end else if (!enable) begin
         cnt  <= '0;
         last <= 1'b0;
      end else if (vld) begin
         last <= bit_in;
         if (cnt == '0 || bit_in != last)
            cnt <= W'(1);
         else if (cnt != W'(SAT))
            cnt <= cnt + W'(1);
      end
   end

   assign fail = (cnt == W'(SAT));

   p_run_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= W'(SAT));

   p_run_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && vld && cnt != '0 && bit_in != last) |=> !fail);

endmodule

// File: rtl/ehm_pair_counter.sv
module ehm_pair_counter
   import ehm_pkg::*;
#(
   parameter int LIMIT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic vld,
   input  logic bit_in,
   output logic fail
);
   localparam int SAT = LIMIT + 1;
   localparam int W   = $clog2(SAT + 1);

   logic [W-1:0] cnt;
   logic         phase;
   logic         first;
   pair_t        prev;
   pair_t        cur;

   assign cur = pair_t'({first, bit_in});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
         first <= 1'b0;
         prev  <= PR_00;
      end else if (!enable) begin
         cnt   <= '0;
         phase <= 1'b0;
         first <= 1'b0;
         prev  <= PR_00;
      end else if (vld) begin
         if (!phase) begin
            first <= bit_in;
            phase <= 1'b1;
         end else begin
            phase <= 1'b0;
            prev  <= cur;
            if (!pair_alternates(cur))
               cnt <= '0;
            else if (cnt != '0 && cur == prev) begin
               if (cnt != W'(SAT))
                  cnt <= cnt + W'(1);
            end else
               cnt <= W'(1);
         end
      end
   end

   assign fail = (cnt == W'(SAT));

   p_pair_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= W'(SAT));

   p_pair_flat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && vld && phase && !pair_alternates(cur)) |=> !fail);

endmodule

// File: rtl/ehm_src_lane.sv
module ehm_src_lane #(
   parameter int RUN_LIMIT  = 64,
   parameter int PAIR_LIMIT = 32,
   parameter bit PAIR_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic vld,
   input  logic bit_in,
   output logic fail
);
   logic run_fail;
   logic pair_fail;

   ehm_run_counter #(.LIMIT(RUN_LIMIT)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .vld    (vld),
      .bit_in (bit_in),
      .fail   (run_fail)
   );

   if (PAIR_EN) begin : g_pair
      ehm_pair_counter #(.LIMIT(PAIR_LIMIT)) u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (enable),
         .vld    (vld),
         .bit_in (bit_in),
         .fail   (pair_fail)
      );
   end else begin : g_no_pair
      assign pair_fail = 1'b0;
   end

   assign fail = run_fail | pair_fail;

endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon #(
   parameter int N_SRC      = 2,
   parameter int RUN_LIMIT  = 64,
   parameter int PAIR_LIMIT = 32,
   parameter bit PAIR_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             irq_en,
   input  logic [N_SRC-1:0] smp_bit,
   input  logic [N_SRC-1:0] smp_vld,
   input  logic             stat_clr,
   input  logic             irq_clr,
   output logic [N_SRC-1:0] src_err,
   output logic             err_live,
   output logic             err_status,
   output logic             irq
);
   if (N_SRC < 1) begin : g_bad_nsrc
      $error("entropy_health_mon: N_SRC must be at least 1");
   end
   if (RUN_LIMIT < 2) begin : g_bad_run
      $error("entropy_health_mon: RUN_LIMIT must be at least 2");
   end
   if (PAIR_LIMIT < 2) begin : g_bad_pair
      $error("entropy_health_mon: PAIR_LIMIT must be at least 2");
   end

   logic [N_SRC-1:0] live_src;
   logic [N_SRC-1:0] sticky_q;
   logic             irq_q;
   logic             any_live;

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_lane
      ehm_src_lane #(
         .RUN_LIMIT  (RUN_LIMIT),
         .PAIR_LIMIT (PAIR_LIMIT),
         .PAIR_EN    (PAIR_EN)
      ) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (enable),
         .vld    (smp_vld[gi]),
         .bit_in (smp_bit[gi]),
         .fail   (live_src[gi])
      );
   end

   assign any_live = |live_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         sticky_q <= (stat_clr ? '0 : sticky_q) | live_src;
         irq_q    <= (irq_clr ? 1'b0 : irq_q) | (irq_en & any_live);
      end
   end

   assign src_err    = sticky_q;
   assign err_live   = any_live;
   assign err_status = |sticky_q;
   assign irq        = irq_q;

   p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_status && !stat_clr) |=> err_status);

   p_status_follows_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_live |=> err_status);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_en));

   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !err_live);

endmodule

// File: tb/entropy_health_mon_bench.sv
`timescale 1ns/1ps
module entropy_health_mon_bench;
   localparam int NS = 2;
   localparam int RL = 64;
   localparam int PL = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          irq_en = 1'b1;
   logic [NS-1:0] smp_bit = '0;
   logic [NS-1:0] smp_vld = '0;
   logic          stat_clr = 1'b0;
   logic          irq_clr = 1'b0;
   logic [NS-1:0] src_err;
   logic          err_live;
   logic          err_status;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   entropy_health_mon #(.N_SRC(NS), .RUN_LIMIT(RL), .PAIR_LIMIT(PL)) u_entropy_health_mon (
      .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
      .smp_bit(smp_bit), .smp_vld(smp_vld), .stat_clr(stat_clr), .irq_clr(irq_clr),
      .src_err(src_err), .err_live(err_live), .err_status(err_status), .irq(irq)
   );

   task automatic check(string tag, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic restart();
      enable = 1'b0; step();
      stat_clr = 1'b1; irq_clr = 1'b1; step();
      stat_clr = 1'b0; irq_clr = 1'b0; enable = 1'b1; step();
   endtask

   task automatic send(int src, logic b);
      smp_bit[src] = b; smp_vld[src] = 1'b1;
      step();
      smp_vld[src] = 1'b0;
   endtask

   task automatic send_pair(int src, logic a, logic b);
      send(src, a); send(src, b);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      check("reset src_err R7", |src_err, 1'b0);
      check("reset irq R9", irq, 1'b0);
      rst_n = 1'b1;
      step();

      // R1 / R2: constant run sweep across threshold, both values
      for (int b = 0; b < 2; b++) begin
         for (int len = RL - 3; len <= RL + 4; len++) begin
            restart();
            for (int k = 0; k < len; k++) send(0, logic'(b));
            check(b == 0 ? "R1 live zeros" : "R2 live ones", err_live, logic'(len > RL));
            step();
            check("R5 src0 flag", src_err[0], logic'(len > RL));
            check("R5 src1 quiet", src_err[1], 1'b0);
         end
      end

      // R3: pair sweep, both patterns, on source 1
      for (int pat = 0; pat < 2; pat++) begin
         for (int n = PL - 2; n <= PL + 3; n++) begin
            restart();
            for (int k = 0; k < n; k++) send_pair(1, logic'(pat), logic'(1 - pat));
            check("R3 pair live", err_live, logic'(n > PL));
            step();
            check("R3 src1 flag", src_err[1], logic'(n > PL));
            check("R5 src0 quiet", src_err[0], 1'b0);
         end
      end

      // R4: swapped pair restarts count
      restart();
      for (int k = 0; k < PL; k++) send_pair(0, 1'b0, 1'b1);
      send_pair(0, 1'b1, 1'b0);
      for (int k = 0; k < PL - 1; k++) send_pair(0, 1'b1, 1'b0);
      check("R4 swap restarts", err_live, 1'b0);
      send_pair(0, 1'b1, 1'b0);
      check("R4 swap then 33rd", err_live, 1'b1);

      // R4: flat pair zeroes count
      restart();
      for (int k = 0; k < PL; k++) send_pair(0, 1'b0, 1'b1);
      send_pair(0, 1'b0, 1'b0);
      for (int k = 0; k < PL; k++) send_pair(0, 1'b0, 1'b1);
      check("R4 flat resets", err_live, 1'b0);
      send_pair(0, 1'b0, 1'b1);
      check("R4 flat then 33rd", err_live, 1'b1);

      // R6: invalid cycles with toggling data are ignored
      restart();
      for (int k = 0; k < RL + 1; k++) begin
         send(0, 1'b1);
         smp_bit[0] = 1'b0; step();
      end
      check("R6 gaps ignored", err_live, 1'b1);

      // R7 / R8: break, sticky hold, clear while live and after
      restart();
      for (int k = 0; k < RL + 1; k++) send(0, 1'b1);
      stat_clr = 1'b1; step(); stat_clr = 1'b0;
      check("R7 clear while live", src_err[0], 1'b1);
      send(0, 1'b0);
      check("R8 live drops", err_live, 1'b0);
      step();
      check("R7 sticky stays", src_err[0], 1'b1);
      stat_clr = 1'b1; step(); stat_clr = 1'b0;
      check("R7 cleared", err_status, 1'b0);

      // R8: pair break drops live
      restart();
      for (int k = 0; k < PL + 1; k++) send_pair(1, 1'b1, 1'b0);
      check("R8 pair live", err_live, 1'b1);
      send(1, 1'b1);
      check("R8 half pair keeps live", err_live, 1'b1);
      send(1, 1'b1);
      check("R8 pair broken", err_live, 1'b0);

      // R9: interrupt gating and clearing
      irq_en = 1'b0;
      restart();
      for (int k = 0; k < RL + 1; k++) send(0, 1'b0);
      step();
      check("R9 no irq when disabled", irq, 1'b0);
      check("R9 status still set", err_status, 1'b1);
      irq_en = 1'b1; step();
      check("R9 irq sets", irq, 1'b1);
      send(0, 1'b1);
      stat_clr = 1'b1; step(); stat_clr = 1'b0;
      check("R9 stat_clr leaves irq", irq, 1'b1);
      check("R9 status cleared", err_status, 1'b0);
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      check("R9 irq cleared", irq, 1'b0);

      // R10: disable mid-run restarts count
      restart();
      for (int k = 0; k < 40; k++) send(0, 1'b1);
      enable = 1'b0; step(); enable = 1'b1;
      for (int k = 0; k < 40; k++) send(0, 1'b1);
      check("R10 disable restarts run", err_live, 1'b0);
      // R10: bits ignored while disabled
      enable = 1'b0;
      for (int k = 0; k < RL + 4; k++) send(1, 1'b0);
      step();
      check("R10 ignored while off", err_status, 1'b0);
      enable = 1'b1; step();
      // R10: alignment restarts: odd bit then disable, pairs align fresh
      send(1, 1'b1);
      enable = 1'b0; step(); enable = 1'b1;
      for (int k = 0; k < PL + 1; k++) send_pair(1, 1'b0, 1'b1);
      check("R10 alignment reset", err_live, 1'b1);

      // R11: long run saturates without wrap
      restart();
      for (int k = 0; k < 300; k++) send(1, 1'b1);
      check("R11 saturates", err_live, 1'b1);

      // R5: concurrent sources
      restart();
      for (int k = 0; k < RL + 1; k++) begin
         smp_bit = {1'b1, logic'(k % 2)};
         smp_vld = 2'b11;
         step();
      end
      smp_vld = '0;
      step();
      check("R5 src1 only", src_err[1], 1'b1);
      check("R5 src0 clean", src_err[0], 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule